// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Output Compare

This block is a 32-bit periodic timer on a word-addressed register bus. Five registers are visible: control, status, load, compare and count. A down-counter advances on prescaled ticks taken from one of three tick-enable inputs. When it reaches zero, it either reloads from the load register or wraps to all ones. A compare flag is set when the counter arrives at the compare value. That flag drives a level interrupt, gated by two control bits.

Software selects the tick source and the divide ratio. It starts the counter with an enable bit, optionally from a fixed starting point. It can overwrite the running count through the load register and acknowledges the flag by writing one to the status register. A self-clearing soft-reset bit in the control register returns most of the state to its reset values. It keeps the enable bit, the start-mode bit and the four low-power bits. The low-power bits (stop, doze, wait, debug) are stored only.

Top module: `dn_timer_cmp`

## Requirements
- R1: Word addresses: control 0, status 1, load 2, compare 3, count 4. Count reads the live counter. Any other address reads zero. Reads are combinational on the address.
- R2: A control write keeps bits 25:0, and bits 31:26 always read zero. Control bit positions: enable 0, start-mode 1, compare-interrupt-enable 2, reload 3, prescale 15:4, soft-reset 16, overwrite 17, low-power bits 21:18, reserved 23:22 stored as written, source 25:24.
- R3: Source field codes are 00 none (the counter never moves), 01 the main tick input, 10 the fast tick input and 11 the slow tick input. The counter moves once per (prescale+1) ticks of the selected input.
- R4: Hardware reset clears control, status, compare and count, and sets load to 0xFFFFFFFF. A control write with bit 16 set keeps only written bits 0, 1 and 21:18. It clears status and compare and sets load to 0xFFFFFFFF. It sets count to 0xFFFFFFFF if the written enable is 1, else to 0. Bit 16 reads back as 1 for one cycle and then clears.
- R5: A control write that raises enable from 0 to 1 with start-mode set loads the counter from load (reload set) or with 0xFFFFFFFF (reload clear). With start-mode clear, the counter resumes from its held value.
- R6: On a tick at count zero, the counter takes the load value in reload mode and wraps to 0xFFFFFFFF in free-running mode. Otherwise a tick decrements it.
- R7: With overwrite set, a load write also places the written value in the counter on the same edge, in either mode. With overwrite clear, a load write changes only the load register and so only the next reload.
- R8: The status flag (status bit 0) is set on a tick whose new count equals compare, but only while enable and compare-interrupt-enable are both 1.
- R9: Writing status with bit 0 at 1 clears the flag, and writing bit 0 at 0 leaves it. When a set and a clear meet on the same edge, the set wins.
- R10: The interrupt output is 1 exactly when the flag, compare-interrupt-enable and enable are all 1.
- R11: While enable is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_tick_main | input | 1 | Main source tick enable (code 01) |
| src_tick_fast | input | 1 | Fast source tick enable (code 10) |
| src_tick_slow | input | 1 | Slow source tick enable (code 11) |
| irq | output | 1 | Level interrupt |

## Verification
Read data and the interrupt are combinational on registered state, so they follow the address in the same cycle. Every register change appears one edge after the write or tick that causes it: the counter, the flag, the control bits and the self-clear of soft reset. The soft-reset bit is visible for exactly one cycle after the write edge and has cleared after the following edge. The bench drives inputs one time unit after a rising edge and samples at the falling edge. It checks the read data and the interrupt each cycle against a behavioural model that is also advanced at the rising edge. Targeted reads against fixed constants sit at the exact cycle after each write.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   localparam int CR_W    = 26;
   localparam int PSC_W   = 12;
   localparam int B_EN    = 0;
   localparam int B_ENMOD = 1;
   localparam int B_OCIEN = 2;
   localparam int B_RLD   = 3;
   localparam int B_PS    = 4;
   localparam int B_SWR   = 16;
   localparam int B_OVW   = 17;
   localparam int B_SRC   = 24;
   // bits that survive a soft reset: enable, start-mode, four low-power bits
   localparam logic [CR_W-1:0] CR_KEEP = 26'h03C0003;
   localparam int A_CTRL = 0;
   localparam int A_STAT = 1;
   localparam int A_LOAD = 2;
   localparam int A_CMP  = 3;
   localparam int A_CNT  = 4;
endpackage

// File: rtl/dtc_prescale.sv
module dtc_prescale #(
   parameter int PS_W  = 12,
   parameter bit PS_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [1:0]      src_sel,
   input  logic [PS_W-1:0] ps_val,
   input  logic            tick_main,
   input  logic            tick_fast,
   input  logic            tick_slow,
   output logic            ptick
);
   logic [3:0] src_vec;
   logic       src_t;

   assign src_vec = {tick_slow, tick_fast, tick_main, 1'b0};
   assign src_t   = src_vec[src_sel];

   generate
      if (PS_EN) begin : g_div
         logic [PS_W-1:0] div_q;
         logic            at_lim;
         assign at_lim = (div_q >= ps_val);
         assign ptick  = en && src_t && at_lim;
         always_ff @(posedge clk) begin
            if (!rst_n)     div_q <= '0;
            else if (!en)   div_q <= '0;
            else if (src_t) div_q <= at_lim ? '0 : div_q + 1'b1;
         end
      end else begin : g_bypass
         logic unused_ps;
         assign unused_ps = ^{ps_val, clk, rst_n};
         assign ptick     = en && src_t;
      end
   endgenerate
endmodule

// File: rtl/dtc_regs.sv
module dtc_regs
   import dtc_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [CR_W-1:0] cr_q,
   output logic [DW-1:0]   load_q,
   output logic [DW-1:0]   cmp_q,
   output logic            swr_evt,
   output logic            en_rise,
   output logic            ld_wr,
   output logic            st_clr
);
   logic wr_ctrl, wr_cmp;

   assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
   assign wr_cmp  = wr_en && (addr == AW'(A_CMP));
   assign ld_wr   = wr_en && (addr == AW'(A_LOAD));
   assign st_clr  = wr_en && (addr == AW'(A_STAT)) && wdata[0];
   assign swr_evt = wr_ctrl && wdata[B_SWR];
   assign en_rise = wr_ctrl && !wdata[B_SWR] && wdata[B_EN] && !cr_q[B_EN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr_q   <= '0;
         load_q <= '1;
         cmp_q  <= '0;
      end else begin
         if (swr_evt)
            cr_q <= (wdata[CR_W-1:0] & CR_KEEP) | (CR_W'(1) << B_SWR);
         else if (wr_ctrl)
            cr_q <= wdata[CR_W-1:0];
         else
            cr_q[B_SWR] <= 1'b0;

         if (swr_evt) begin
            load_q <= '1;
            cmp_q  <= '0;
         end else begin
            if (ld_wr)  load_q <= wdata;
            if (wr_cmp) cmp_q  <= wdata;
         end
      end
   end
endmodule

// File: rtl/dtc_counter.sv
module dtc_counter #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptick,
   input  logic          en,
   input  logic          ocien,
   input  logic          rld,
   input  logic          ovw,
   input  logic          swr_evt,
   input  logic          swr_en,
   input  logic          en_rise,
   input  logic          start_enmod,
   input  logic          start_rld,
   input  logic          ld_wr,
   input  logic [DW-1:0] ld_data,
   input  logic          st_clr,
   input  logic [DW-1:0] load_q,
   input  logic [DW-1:0] cmp_q,
   output logic [DW-1:0] cnt_q,
   output logic          flag_q
);
   logic [DW-1:0] run_nxt, cnt_d;
   logic          hit;

   always_comb begin
      run_nxt = cnt_q;
      if (en && ptick)
         run_nxt = (cnt_q == '0) ? (rld ? load_q : '1) : cnt_q - 1'b1;
      hit   = en && ocien && ptick && (run_nxt == cmp_q);
      cnt_d = run_nxt;
      if (swr_evt)
         cnt_d = swr_en ? '1 : '0;
      else if (en_rise && start_enmod)
         cnt_d = start_rld ? load_q : '1;
      else if (ld_wr && ovw)
         cnt_d = ld_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (swr_evt)     flag_q <= 1'b0;
         else if (hit)    flag_q <= 1'b1;
         else if (st_clr) flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dn_timer_cmp.sv
module dn_timer_cmp
   import dtc_pkg::*;
#(
   parameter int DW    = 32,
   parameter int AW    = 3,
   parameter bit PS_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          src_tick_main,
   input  logic          src_tick_fast,
   input  logic          src_tick_slow,
   output logic          irq
);
   generate
      if (DW < CR_W) begin : g_bad_dw
         $error("dn_timer_cmp: DW must hold the control field");
      end
      if (AW < 3) begin : g_bad_aw
         $error("dn_timer_cmp: AW must reach word 4");
      end
   endgenerate

   logic [CR_W-1:0] cr_q;
   logic [DW-1:0]   load_q, cmp_q, cnt_q;
   logic            swr_evt, en_rise, ld_wr, st_clr, ptick, flag_q;
   logic            unused_lp;

   assign unused_lp = ^cr_q[23:18];

   dtc_regs #(.DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .cr_q(cr_q), .load_q(load_q), .cmp_q(cmp_q),
      .swr_evt(swr_evt), .en_rise(en_rise), .ld_wr(ld_wr), .st_clr(st_clr)
   );

   dtc_prescale #(.PS_W(PSC_W), .PS_EN(PS_EN)) u_psc (
      .clk(clk), .rst_n(rst_n), .en(cr_q[B_EN]),
      .src_sel(cr_q[B_SRC+1:B_SRC]), .ps_val(cr_q[B_PS+PSC_W-1:B_PS]),
      .tick_main(src_tick_main), .tick_fast(src_tick_fast), .tick_slow(src_tick_slow),
      .ptick(ptick)
   );

   dtc_counter #(.DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ptick(ptick),
      .en(cr_q[B_EN]), .ocien(cr_q[B_OCIEN]), .rld(cr_q[B_RLD]), .ovw(cr_q[B_OVW]),
      .swr_evt(swr_evt), .swr_en(bus_wdata[B_EN]), .en_rise(en_rise),
      .start_enmod(bus_wdata[B_ENMOD]), .start_rld(bus_wdata[B_RLD]),
      .ld_wr(ld_wr), .ld_data(bus_wdata), .st_clr(st_clr),
      .load_q(load_q), .cmp_q(cmp_q), .cnt_q(cnt_q), .flag_q(flag_q)
   );

   always_comb begin
      case (bus_addr)
         AW'(A_CTRL): bus_rdata = {{(DW-CR_W){1'b0}}, cr_q};
         AW'(A_STAT): bus_rdata = {{(DW-1){1'b0}}, flag_q};
         AW'(A_LOAD): bus_rdata = load_q;
         AW'(A_CMP):  bus_rdata = cmp_q;
         AW'(A_CNT):  bus_rdata = cnt_q;
         default:     bus_rdata = '0;
      endcase
   end

   assign irq = flag_q && cr_q[B_OCIEN] && cr_q[B_EN];
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk
   import dtc_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_wr,
   input logic [AW-1:0]   bus_addr,
   input logic            wd_bit0,
   input logic            wd_swr,
   input logic [CR_W-1:0] cr_q,
   input logic [DW-1:0]   load_q,
   input logic [DW-1:0]   cmp_q,
   input logic [DW-1:0]   cnt_q,
   input logic            flag_q,
   input logic            ptick
);
   logic wr_ctrl, wr_stat;
   assign wr_ctrl = bus_wr && (bus_addr == AW'(A_CTRL));
   assign wr_stat = bus_wr && (bus_addr == AW'(A_STAT));

   a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!cr_q[B_EN] && !bus_wr) |=> $stable(cnt_q));

   a_r3_no_source_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_q[B_SRC+1:B_SRC] == 2'b00) |-> !ptick);

   a_r6_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ptick && cnt_q == '0 && !cr_q[B_RLD] && !bus_wr) |=> (cnt_q == '1));

   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (ptick && cnt_q == '0 && cr_q[B_RLD] && !bus_wr) |=> (cnt_q == load_q));

   a_r4_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wd_swr) |=> (load_q == '1 && cmp_q == '0 && !flag_q && cr_q[B_SWR]));

   a_r4_swr_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_q[B_SWR] && !wr_ctrl) |=> !cr_q[B_SWR]);

   a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wd_bit0 && !ptick) |=> !flag_q);

   a_r9_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !wd_bit0 && flag_q) |=> flag_q);
endmodule

bind dn_timer_cmp dtc_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .wd_bit0(bus_wdata[0]), .wd_swr(bus_wdata[16]),
   .cr_q(cr_q), .load_q(load_q), .cmp_q(cmp_q), .cnt_q(cnt_q),
   .flag_q(flag_q), .ptick(ptick)
);

// File: tb/test_dn_timer_cmp.sv
module test_dn_timer_cmp;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = 3'd4;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          t_main = 1'b0, t_fast = 1'b0, t_slow = 1'b0;
   logic          irq;

   int    n_chk = 0, n_fail = 0, cyc = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dn_timer_cmp i_dn_timer_cmp (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_tick_main(t_main), .src_tick_fast(t_fast), .src_tick_slow(t_slow),
      .irq(irq)
   );

   task automatic check(string r, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", r, what, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on each rising edge
   logic [25:0] m_cr = '0;
   logic        m_flag = 1'b0;
   logic [31:0] m_load = '1, m_cmp = '0, m_cnt = '0;
   int          m_psc = 0;

   always @(posedge clk) begin : model
      logic src, tk, hit;
      logic [31:0] nx;
      int ps;
      cyc++;
      if (!rst_n) begin
         m_cr = '0; m_flag = 1'b0; m_load = '1; m_cmp = '0; m_cnt = '0; m_psc = 0;
      end else begin
         ps = int'(m_cr[15:4]);
         case (m_cr[25:24])
            2'd0: src = 1'b0;
            2'd1: src = t_main;
            2'd2: src = t_fast;
            default: src = t_slow;
         endcase
         tk = m_cr[0] && src && (m_psc >= ps);
         nx = m_cnt;
         if (tk) nx = (m_cnt == 0) ? (m_cr[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
         hit = tk && m_cr[2] && (nx == m_cmp);
         if (!m_cr[0]) m_psc = 0;
         else if (src) m_psc = tk ? 0 : m_psc + 1;
         if (bus_wr && bus_addr == 0 && bus_wdata[16]) begin
            m_cr   = (bus_wdata[25:0] & 26'h03C0003) | 26'h0010000;
            m_flag = 1'b0; m_load = '1; m_cmp = '0;
            m_cnt  = bus_wdata[0] ? 32'hFFFF_FFFF : 32'h0;
         end else begin
            if (bus_wr && bus_addr == 0 && bus_wdata[0] && !m_cr[0] && bus_wdata[1])
               nx = bus_wdata[3] ? m_load : 32'hFFFF_FFFF;
            if (bus_wr && bus_addr == 2 && m_cr[17]) nx = bus_wdata;
            if (hit) m_flag = 1'b1;
            else if (bus_wr && bus_addr == 1 && bus_wdata[0]) m_flag = 1'b0;
            m_cnt = nx;
            if (bus_wr && bus_addr == 0) m_cr = bus_wdata[25:0];
            else m_cr[16] = 1'b0;
            if (bus_wr && bus_addr == 2) m_load = bus_wdata;
            if (bus_wr && bus_addr == 3) m_cmp = bus_wdata;
         end
      end
   end

   // tick sources, changed just after each rising edge
   always @(posedge clk) begin
      #1;
      t_main = (cyc % 7) != 3;
      t_fast = (cyc % 2) == 0;
      t_slow = (cyc % 5) == 0;
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin : cmp_every
      logic [31:0] exp;
      if (rst_n && !done) begin
         case (bus_addr)
            3'd0: exp = {6'b0, m_cr};
            3'd1: exp = {31'b0, m_flag};
            3'd2: exp = m_load;
            3'd3: exp = m_cmp;
            3'd4: exp = m_cnt;
            default: exp = 32'h0;
         endcase
         check(cur_req, bus_rdata, exp, "rdata vs model");
         check("R10", {31'b0, irq}, {31'b0, m_flag & m_cr[2] & m_cr[0]}, "irq vs model");
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = 3'd4;
   endtask

   task automatic rd(logic [2:0] a, logic [31:0] exp, string r);
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      check(r, bus_rdata, exp, "read");
      @(posedge clk); #1;
      bus_addr = 3'd4;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin : stim
      logic [31:0] held;
      idle(3);
      @(posedge clk); #1 rst_n = 1'b1;
      // reset values
      cur_req = "R4";
      rd(3'd0, 32'h0, "R4");
      rd(3'd2, 32'hFFFF_FFFF, "R4");
      cur_req = "R1";
      rd(3'd1, 32'h0, "R1");
      rd(3'd6, 32'h0, "R1");
      // control width and stored-only bits
      cur_req = "R2";
      wr(3'd0, 32'hFCFC_0000);
      rd(3'd0, 32'h00FC_0000, "R2");
      // enable with source none: starts at all ones, never moves
      cur_req = "R3";
      wr(3'd0, 32'h0000_0003);
      idle(5);
      rd(3'd4, 32'hFFFF_FFFF, "R3");
      // main source, prescale 2, free-running
      wr(3'd0, 32'h0);
      cur_req = "R5";
      wr(3'd0, 32'h0100_0023);
      cur_req = "R3";
      idle(25);
      // overwrite in free mode, then watch the wrap
      cur_req = "R7";
      wr(3'd0, 32'h0102_0003);
      wr(3'd2, 32'd5);
      @(negedge clk);
      check("R7", bus_rdata, 32'd5, "count after overwrite");
      cur_req = "R6";
      idle(14);
      // reload mode start from load
      wr(3'd0, 32'h0);
      cur_req = "R5";
      wr(3'd0, 32'h0100_000B);
      @(negedge clk);
      check("R5", bus_rdata, 32'd5, "start from load");
      cur_req = "R6";
      idle(20);
      // compare flag and interrupt
      cur_req = "R8";
      wr(3'd3, 32'd2);
      wr(3'd0, 32'h0100_000F);
      idle(15);
      rd(3'd1, 32'h1, "R8");
      cur_req = "R10";
      wr(3'd0, 32'h0100_000B);
      @(negedge clk);
      check("R10", {31'b0, irq}, 32'h0, "irq gated by compare-interrupt-enable");
      rd(3'd1, 32'h1, "R10");
      cur_req = "R9";
      wr(3'd1, 32'h0);
      rd(3'd1, 32'h1, "R9");
      wr(3'd1, 32'h1);
      rd(3'd1, 32'h0, "R9");
      // load write without overwrite only changes next reload
      cur_req = "R7";
      wr(3'd2, 32'd3);
      idle(12);
      // stop holds, resume without start-mode
      cur_req = "R11";
      wr(3'd0, 32'h0100_000A);
      @(negedge clk);
      held = bus_rdata;
      idle(6);
      @(negedge clk);
      check("R11", bus_rdata, held, "count held while off");
      cur_req = "R5";
      wr(3'd0, 32'h0100_0009);
      @(negedge clk);
      check("R5", bus_rdata, held, "resume from held value");
      idle(10);
      // interrupt path live while set again
      cur_req = "R8";
      wr(3'd3, 32'd1);
      wr(3'd0, 32'h0100_000D);
      idle(12);
      // soft reset with enable kept
      cur_req = "R4";
      wr(3'd0, 32'h0101_000F);
      @(negedge clk);
      check("R4", bus_rdata, 32'hFFFF_FFFF, "count after soft reset");
      rd(3'd0, 32'h0000_0003, "R4");
      rd(3'd2, 32'hFFFF_FFFF, "R4");
      rd(3'd3, 32'h0, "R4");
      rd(3'd1, 32'h0, "R4");
      rd(3'd4, 32'hFFFF_FFFF, "R4");
      // slow source, prescale 1
      cur_req = "R3";
      wr(3'd0, 32'h0300_0013);
      idle(30);
      wr(3'd0, 32'h0200_0001);
      idle(20);
      cur_req = "R1";
      rd(3'd5, 32'h0, "R1");
      rd(3'd7, 32'h0, "R1");
      finish_up();
   end
endmodule